// File: doc/BRIEF.md
# Serial LED Driver Chain Loader

This block sits on the host side of a daisy chain of serial-input LED driver devices, each of which has an eight-stage shift register, a transparent output latch and a blanking input. A frame of `NUM_DEV*8` channel bits is handed over through a valid/ready handshake. The block then turns it into a serial data line, a shift clock and a single latch strobe. Afterwards it drives an active-high blanking line that lights the new image for a programmable on-time.

All pin timing comes from the system clock period parameter and from minimum-duration parameters given in nanoseconds. At elaboration these are rounded up to whole clock cycles. The defaults are set so that every shift-clock phase, data setup and hold window, latch pulse and blanking pulse meets the drivers' stated minimums. Every pin leaves the block through one output register stage, so all pins stay aligned with each other to the cycle.

Top module: `ledChainLoader`

## Requirements
- R1: `frameReady` is high only when the block is idle. A frame is taken on a clock edge where `frameValid` and `frameReady` are both high, and `frameReady` is low in the cycle after that. A request made while a frame is in progress is held off and is loaded later, not lost.
- R2: Each frame produces exactly `NUM_DEV*8` rising shift-clock edges. The first bit is `frameData[NUM_DEV*8-1]` and the last is `frameData[0]`, so the most significant byte goes to the device farthest down the chain.
- R3: The data line changes only while the shift clock is low, in the same cycle as a falling clock edge. It is stable at least 60 ns before and at least 20 ns after each rising edge.
- R4: The shift clock is high for at least 50 ns and low for at least 50 ns, and rising edges are at least 100 ns apart.
- R5: Each frame gives exactly one latch pulse, and the latch is low for the whole shift phase. The latch rises at least 100 ns after the last shift-clock edge and is at least 100 ns wide. The next rising shift-clock edge comes at least 60 ns after the latch falls.
- R6: When `blankOnLoad` is 1 at acceptance, `drvBlank` is held high (outputs off) from acceptance through the latch pulse. When it is 0, `drvBlank` is low during loading.
- R7: `drvBlank` goes low when the latch falls and rises again exactly `max(onTime, BLANK_CYC)` cycles later, where `BLANK_CYC` is 4500 ns rounded up to clock cycles (900 at 5 ns). It then stays high for at least `BLANK_CYC` cycles before the next frame is accepted.
- R8: Every high or low pulse on `drvBlank` lasts at least 4500 ns. `drvBlank` is high from reset, and no frame is accepted until the minimum off time after reset has passed.
- R9: `frameDone` is a one-cycle pulse in the cycle in which the latch falls. `busy` is high during shifting and latching, and falls in that same cycle.
- R10: While `rst` is high: `drvSdo`, `drvSclk`, `drvLatch`, `busy`, `frameDone` and `frameReady` are 0, and `drvBlank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frameValid | input | 1 | Frame request |
| frameReady | output | 1 | Idle, frame can be taken |
| frameData | input | NUM_DEV*8 | Channel bits, farthest device in the top byte |
| onTime | input | ON_W | Requested lit time in clock cycles, sampled at acceptance |
| blankOnLoad | input | 1 | Keep outputs blanked while loading, sampled at acceptance |
| drvSdo | output | 1 | Serial data to the first device |
| drvSclk | output | 1 | Shift clock, devices shift on its rising edge |
| drvLatch | output | 1 | Latch strobe, transparent while high |
| drvBlank | output | 1 | Output blanking, high = all channels off |
| busy | output | 1 | Shift or latch phase in progress |
| frameDone | output | 1 | One-cycle pulse when the frame reaches the latches |

## Verification
The assertions assume that `frameValid`, `frameData`, `onTime` and `blankOnLoad` are stable in the cycle they are sampled. They also assume that the period parameter matches the actual clock, because every pulse-width check counts cycles. The bench changes its inputs only on the falling clock edge and waits for `frameReady` before dropping `frameValid`, so no request is withdrawn while it is held off. It runs with a clock period equal to the parameter value.

// File: rtl/ledChainPkg.sv
package ledChainPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LATWAIT,
    ST_LATCH,
    ST_ON,
    ST_OFFHOLD
  } seqState_t;

  // Control-to-datapath strobes and pin levels (one cycle ahead of the pins)
  typedef struct packed {
    logic load;
    logic advance;
    logic sclk;
    logic lat;
    logic blank;
    logic busy;
    logic done;
  } drvStrobe_t;

  function automatic int cdiv(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ledChainControl.sv
module ledChainControl
  import ledChainPkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int ON_W      = 16,
  parameter int HI_CYC    = 10,
  parameter int LO_CYC    = 12,
  parameter int LATSU_CYC = 20,
  parameter int LATW_CYC  = 20,
  parameter int BLANK_CYC = 900
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frameValid,
  output logic            frameReady,
  input  logic [ON_W-1:0] onTime,
  input  logic            blankOnLoad,
  output drvStrobe_t      strobe
);

  localparam int K_MAX = maxi(maxi(HI_CYC, LO_CYC), maxi(maxi(LATSU_CYC, LATW_CYC), BLANK_CYC));
  localparam int K_W   = $clog2(K_MAX + 1);
  localparam int CNT_W = (ON_W > K_W) ? ON_W : K_W;
  localparam int BIT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  localparam logic [CNT_W-1:0] HI_M1    = CNT_W'(HI_CYC - 1);
  localparam logic [CNT_W-1:0] LO_M1    = CNT_W'(LO_CYC - 1);
  localparam logic [CNT_W-1:0] LATSU_M1 = CNT_W'(LATSU_CYC - 1);
  localparam logic [CNT_W-1:0] LATW_M1  = CNT_W'(LATW_CYC - 1);
  localparam logic [CNT_W-1:0] BLANK_V  = CNT_W'(BLANK_CYC);
  localparam logic [CNT_W-1:0] BLANK_M1 = CNT_W'(BLANK_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  seqState_t        state, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic [ON_W-1:0]  cfgOn;
  logic             cfgBlank;
  logic             firstOn;
  logic             tick;
  logic             loading;
  logic [CNT_W-1:0] onExt;
  logic [CNT_W-1:0] onLoad;

  assign tick       = (cnt == '0);
  assign frameReady = (state == ST_IDLE);
  assign onExt      = CNT_W'(cfgOn);
  // Lit window never shorter than the minimum blanking pulse width
  assign onLoad     = (onExt < BLANK_V) ? BLANK_M1 : (onExt - 1'b1);
  assign loading    = (state == ST_SETUP) || (state == ST_HIGH) ||
                      (state == ST_LATWAIT) || (state == ST_LATCH);

  always_comb begin
    stNext  = state;
    cntNext = tick ? cnt : (cnt - 1'b1);
    bitNext = bitCnt;
    strobe  = '0;
    unique case (state)
      ST_IDLE: begin
        if (frameValid) begin
          stNext      = ST_SETUP;
          cntNext     = LO_M1;
          bitNext     = BIT_LAST;
          strobe.load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          stNext  = ST_HIGH;
          cntNext = HI_M1;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          if (bitCnt == '0) begin
            stNext  = ST_LATWAIT;
            cntNext = LATSU_M1;
          end else begin
            stNext         = ST_SETUP;
            cntNext        = LO_M1;
            bitNext        = bitCnt - 1'b1;
            strobe.advance = 1'b1;
          end
        end
      end
      ST_LATWAIT: begin
        if (tick) begin
          stNext  = ST_LATCH;
          cntNext = LATW_M1;
        end
      end
      ST_LATCH: begin
        if (tick) begin
          stNext  = ST_ON;
          cntNext = onLoad;
        end
      end
      ST_ON: begin
        if (tick) begin
          stNext  = ST_OFFHOLD;
          cntNext = BLANK_M1;
        end
      end
      ST_OFFHOLD: begin
        if (tick) stNext = ST_IDLE;
      end
      default: begin
        stNext  = ST_OFFHOLD;
        cntNext = BLANK_M1;
      end
    endcase
    strobe.sclk  = (state == ST_HIGH);
    strobe.lat   = (state == ST_LATCH);
    strobe.busy  = loading;
    strobe.blank = (state == ST_ON) ? 1'b0 : (loading ? cfgBlank : 1'b1);
    strobe.done  = firstOn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFFHOLD;
      cnt      <= BLANK_M1;
      bitCnt   <= '0;
      cfgOn    <= '0;
      cfgBlank <= 1'b1;
      firstOn  <= 1'b0;
    end else begin
      state   <= stNext;
      cnt     <= cntNext;
      bitCnt  <= bitNext;
      firstOn <= (state == ST_LATCH) && tick;
      if (strobe.load) begin
        cfgOn    <= onTime;
        cfgBlank <= blankOnLoad;
      end
    end
  end

  // R5: the latch sequence only starts once every bit has been clocked out
  p_latch_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATWAIT) |-> (bitCnt == '0));

  // R7: settings sampled at acceptance hold for the whole frame
  p_cfg_held_r7: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(cfgOn) && $stable(cfgBlank)));

endmodule

// File: rtl/ledChainDatapath.sv
module ledChainDatapath
  import ledChainPkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int BLANK_CYC = 900
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frameData,
  input  drvStrobe_t         strobe,
  output logic               sdoOut,
  output logic               sclkOut,
  output logic               latOut,
  output logic               blankOut,
  output logic               busyOut,
  output logic               doneOut
);

  localparam int RUN_W = $clog2(BLANK_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(BLANK_CYC);
  localparam logic [RUN_W-1:0] RUN_MIN = RUN_W'(BLANK_CYC - 1);

  logic [FRAME_W-1:0] shreg;
  logic [RUN_W-1:0]   runCnt;

  // Frame word, most significant bit leaves first
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (strobe.load) begin
      shreg <= frameData;
    end else if (strobe.advance) begin
      shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  // One common output stage keeps every pin on the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      sdoOut   <= 1'b0;
      sclkOut  <= 1'b0;
      latOut   <= 1'b0;
      blankOut <= 1'b1;
      busyOut  <= 1'b0;
      doneOut  <= 1'b0;
    end else begin
      sdoOut   <= shreg[FRAME_W-1];
      sclkOut  <= strobe.sclk;
      latOut   <= strobe.lat;
      blankOut <= strobe.blank;
      busyOut  <= strobe.busy;
      doneOut  <= strobe.done;
    end
  end

  // Cycles since the blanking pin last changed, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (strobe.blank != blankOut) begin
      runCnt <= '0;
    end else if (runCnt != RUN_MAX) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R5: the transparent latch is never open while the clock is high
  p_lat_clk_low_r5: assert property (@(posedge clk) disable iff (rst)
    latOut |-> !sclkOut);

  // R3: data holds steady whenever the shift clock is high
  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    sclkOut |-> $stable(sdoOut));

  // R8: blanking pin changes only after the minimum pulse width
  p_blank_min_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.blank != blankOut) |-> (runCnt >= RUN_MIN));

endmodule

// File: rtl/ledChainLoader.sv
module ledChainLoader
  import ledChainPkg::*;
#(
  parameter int NUM_DEV      = 2,
  parameter int ON_W         = 16,
  parameter int CLK_NS       = 5,
  parameter int SCLK_HI_NS   = 50,
  parameter int SCLK_LO_NS   = 50,
  parameter int SCLK_PER_NS  = 100,
  parameter int DAT_SU_NS    = 60,
  parameter int DAT_HD_NS    = 20,
  parameter int LAT_SU_NS    = 100,
  parameter int LAT_W_NS     = 100,
  parameter int BLANK_MIN_NS = 4500
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frameValid,
  output logic                   frameReady,
  input  logic [NUM_DEV*8-1:0]   frameData,
  input  logic [ON_W-1:0]        onTime,
  input  logic                   blankOnLoad,
  output logic                   drvSdo,
  output logic                   drvSclk,
  output logic                   drvLatch,
  output logic                   drvBlank,
  output logic                   busy,
  output logic                   frameDone
);

  localparam int FRAME_W   = NUM_DEV * 8;
  localparam int HI_CYC    = maxi(cdiv(SCLK_HI_NS, CLK_NS), cdiv(DAT_HD_NS, CLK_NS));
  localparam int LO_BASE   = maxi(cdiv(SCLK_LO_NS, CLK_NS), cdiv(DAT_SU_NS, CLK_NS));
  localparam int PER_CYC   = cdiv(SCLK_PER_NS, CLK_NS);
  localparam int LO_CYC    = (HI_CYC + LO_BASE < PER_CYC) ? (PER_CYC - HI_CYC) : LO_BASE;
  localparam int LATSU_CYC = cdiv(LAT_SU_NS, CLK_NS);
  localparam int LATW_CYC  = cdiv(LAT_W_NS, CLK_NS);
  localparam int BLANK_CYC = cdiv(BLANK_MIN_NS, CLK_NS);

  drvStrobe_t strobe;

  ledChainControl #(
    .FRAME_W  (FRAME_W),
    .ON_W     (ON_W),
    .HI_CYC   (HI_CYC),
    .LO_CYC   (LO_CYC),
    .LATSU_CYC(LATSU_CYC),
    .LATW_CYC (LATW_CYC),
    .BLANK_CYC(BLANK_CYC)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frameValid (frameValid),
    .frameReady (frameReady),
    .onTime     (onTime),
    .blankOnLoad(blankOnLoad),
    .strobe     (strobe)
  );

  ledChainDatapath #(
    .FRAME_W  (FRAME_W),
    .BLANK_CYC(BLANK_CYC)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .frameData(frameData),
    .strobe   (strobe),
    .sdoOut   (drvSdo),
    .sclkOut  (drvSclk),
    .latOut   (drvLatch),
    .blankOut (drvBlank),
    .busyOut  (busy),
    .doneOut  (frameDone)
  );

  // R1: no frame is offered while one is still being shifted or latched
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (rst)
    busy |-> !frameReady);

endmodule

// File: tb/test_ledChainLoader.sv
`timescale 1ns/1ps
module test_ledChainLoader;

  localparam int NUM_DEV = 2;
  localparam int FW      = NUM_DEV * 8;
  localparam int ON_W    = 16;
  localparam int CLK_NS  = 5;
  // Stated minimums in ns
  localparam int MIN_HI  = 50;
  localparam int MIN_LO  = 50;
  localparam int MIN_PER = 100;
  localparam int MIN_SU  = 60;
  localparam int MIN_HD  = 20;
  localparam int MIN_LSU = 100;
  localparam int MIN_LW  = 100;
  localparam int MIN_LHD = 60;
  localparam int MIN_BL  = 4500;
  localparam int BC      = (MIN_BL + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameValid = 1'b0;
  logic [FW-1:0] frameData = '0;
  logic [ON_W-1:0] onTime = '0;
  logic blankOnLoad = 1'b0;
  logic frameReady, drvSdo, drvSclk, drvLatch, drvBlank, busy, frameDone;

  always #2.5 clk = ~clk;

  ledChainLoader #(.NUM_DEV(NUM_DEV), .ON_W(ON_W), .CLK_NS(CLK_NS)) i_ledChainLoader (
    .clk(clk), .rst(rst), .frameValid(frameValid), .frameReady(frameReady),
    .frameData(frameData), .onTime(onTime), .blankOnLoad(blankOnLoad),
    .drvSdo(drvSdo), .drvSclk(drvSclk), .drvLatch(drvLatch), .drvBlank(drvBlank),
    .busy(busy), .frameDone(frameDone)
  );

  int nVec = 0;
  int nErr = 0;
  bit finished = 0;
  longint cyc = 0;

  logic [FW-1:0] expFrame [0:31];
  int            expOn    [0:31];
  bit            expBl    [0:31];
  int nSent = 0;
  int latCount = 0;
  int doneCount = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pin monitor: all intervals in ns from the cycle count
  logic pSclk = 0, pSdo = 0, pLat = 0, pBlank = 1, pDone = 0, pBusy = 0;
  longint tRise = -100000, tFall = -100000, tSdo = -100000;
  longint tLatRise = -100000, tLatFall = -100000, tBlankChg = 0;
  logic [FW-1:0] got = '0;
  int nBits = 0;
  longint now;

  always @(negedge clk) begin
    if (rst) begin
      pSclk = 0; pSdo = 0; pLat = 0; pBlank = 1; pDone = 0; pBusy = 0;
      tBlankChg = cyc * CLK_NS;
    end else begin
      now = cyc * CLK_NS;
      if (drvSdo !== pSdo) begin
        chk(!drvSclk, "R3", "data moved with clock high", longint'(drvSclk), 0);
        if (pSclk) chk(now - tRise >= MIN_HD, "R3", "hold ns", now - tRise, MIN_HD);
        tSdo = now;
      end
      if (drvSclk && !pSclk) begin
        chk(now - tSdo >= MIN_SU, "R3", "setup ns", now - tSdo, MIN_SU);
        chk(now - tFall >= MIN_LO, "R4", "clock low ns", now - tFall, MIN_LO);
        chk(now - tRise >= MIN_PER, "R4", "clock period ns", now - tRise, MIN_PER);
        chk(now - tLatFall >= MIN_LHD, "R5", "latch fall to clock ns", now - tLatFall, MIN_LHD);
        chk(!drvLatch, "R5", "latch during shift", longint'(drvLatch), 0);
        chk(busy, "R9", "busy during shift", longint'(busy), 1);
        chk(drvBlank == expBl[latCount], "R6", "blank while loading",
            longint'(drvBlank), longint'(expBl[latCount]));
        got = {got[FW-2:0], drvSdo};
        nBits++;
        tRise = now;
      end
      if (!drvSclk && pSclk) begin
        chk(now - tRise >= MIN_HI, "R4", "clock high ns", now - tRise, MIN_HI);
        tFall = now;
      end
      if (drvLatch && !pLat) begin
        chk(now - tFall >= MIN_LSU, "R5", "last clock to latch ns", now - tFall, MIN_LSU);
        chk(nBits == FW, "R2", "clock edges per frame", nBits, FW);
        chk(got == expFrame[latCount], "R2", "bits shifted", longint'(got),
            longint'(expFrame[latCount]));
        chk(drvBlank == expBl[latCount], "R6", "blank at latch",
            longint'(drvBlank), longint'(expBl[latCount]));
        latCount++;
        tLatRise = now;
      end
      if (!drvLatch && pLat) begin
        chk(now - tLatRise >= MIN_LW, "R5", "latch width ns", now - tLatRise, MIN_LW);
        chk(frameDone, "R9", "done with latch fall", longint'(frameDone), 1);
        chk(!busy && pBusy, "R9", "busy falls with latch", longint'(busy), 0);
        nBits = 0;
        tLatFall = now;
      end
      if (frameDone) begin
        chk(!pDone, "R9", "done longer than one cycle", longint'(pDone), 0);
        chk(pLat && !drvLatch, "R9", "done away from latch fall", longint'(drvLatch), 0);
        doneCount++;
      end
      if (drvBlank !== pBlank) begin
        chk(now - tBlankChg >= MIN_BL, "R8", "blank pulse ns", now - tBlankChg, MIN_BL);
        if (drvBlank && latCount > 0)
          chk(now - tLatFall == longint'(expOn[latCount-1]) * CLK_NS, "R7", "lit window ns",
              now - tLatFall, longint'(expOn[latCount-1]) * CLK_NS);
        tBlankChg = now;
      end
      pSclk = drvSclk; pSdo = drvSdo; pLat = drvLatch;
      pBlank = drvBlank; pDone = frameDone; pBusy = busy;
    end
  end

  task automatic sendFrame(input logic [FW-1:0] d, input int onT, input bit bl,
                           output int waited);
    waited = 0;
    @(negedge clk);
    frameValid = 1'b1;
    frameData = d;
    onTime = ON_W'(onT);
    blankOnLoad = bl;
    expFrame[nSent] = d;
    expOn[nSent] = (onT < BC) ? BC : onT;
    expBl[nSent] = bl;
    nSent++;
    while (!frameReady) begin
      waited++;
      @(negedge clk);
    end
    @(negedge clk);
    frameValid = 1'b0;
    chk(!frameReady, "R1", "ready after accept", longint'(frameReady), 0);
  endtask

  function automatic int onPick(input int k);
    case (k % 6)
      0: return 0;
      1: return 1;
      2: return BC - 1;
      3: return BC;
      4: return BC + 1;
      default: return 1000;
    endcase
  endfunction

  initial begin
    int w;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(!drvSdo, "R10", "sdo in reset", longint'(drvSdo), 0);
    chk(!drvSclk, "R10", "sclk in reset", longint'(drvSclk), 0);
    chk(!drvLatch, "R10", "latch in reset", longint'(drvLatch), 0);
    chk(drvBlank, "R10", "blank in reset", longint'(drvBlank), 1);
    chk(!frameReady, "R10", "ready in reset", longint'(frameReady), 0);
    chk(!busy, "R10", "busy in reset", longint'(busy), 0);
    chk(!frameDone, "R10", "done in reset", longint'(frameDone), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(!frameReady, "R8", "ready during off time after reset", longint'(frameReady), 0);
    chk(drvBlank, "R8", "blank after reset", longint'(drvBlank), 1);

    // Walking ones, all zeros, all ones, with on-time and blanking sweeps
    for (int f = 0; f < 18; f++) begin
      logic [FW-1:0] d;
      if (f < FW) d = FW'(1) << f;
      else if (f == FW) d = '0;
      else d = '1;
      sendFrame(d, onPick(f), (f % 3) != 0, w);
    end

    // R1: back-to-back request held off, then delivered
    sendFrame(16'hA5C3, onPick(2), 1'b1, w);
    sendFrame(16'h3C96, onPick(4), 1'b0, w);
    chk(w > 0, "R1", "second request held off", w, 1);

    while (!frameReady) @(negedge clk);
    chk(latCount == nSent, "R5", "one latch per frame", latCount, nSent);
    chk(doneCount == nSent, "R9", "one done per frame", doneCount, nSent);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

endmodule